// File: doc/BRIEF.md
# DDS Serial Word Loader

This block drives the three-wire serial programming port of a direct digital synthesis chip from inside a larger design. A caller presents a 32-bit frequency tuning word, a reference-multiplier enable and a 5-bit phase code, and strobes `start`. The loader captures these values and assembles a 40-bit programming word. It shifts the word out on the data and word-clock lines and then pulses the frequency-update line, so the chip adopts the new setting.

The synthesis chip powers up in parallel-load mode. The first transfer after every reset is therefore preceded by a switch-over sequence: a single word-clock pulse, then a single frequency-update pulse. Every line phase lasts `PHASE_CYC` system clocks, so the bit rate can be slowed to suit the chip and the board. `busy` covers the whole transfer, and `done` marks its end with a one-cycle pulse. The caller must compute the tuning word itself.

Top module: `dds_word_loader`

## Requirements
- R1: While reset is asserted and directly after it, `sdata`, `wclk`, `fqud`, `busy` and `done` are all low.
- R2: The first accepted transfer after reset begins with `wclk` high for PHASE_CYC cycles, then all lines low for PHASE_CYC cycles, then `fqud` high for PHASE_CYC cycles. Later transfers omit this prefix until the next reset.
- R3: Word bits 31:0 carry the tuning word and are sent first, bit 0 first. Word bits 39:32 carry the control byte, also bit 0 first. That makes 40 clocked bits in all.
- R4: In the control byte, bit 0 is the ×6 multiplier enable, bits 2:1 are zero and bits 7:3 hold the phase code (one step equals 11.25 degrees).
- R5: Each bit takes three phases of PHASE_CYC cycles each, with `sdata` holding the bit throughout: `wclk` low, then `wclk` high, then `wclk` low.
- R6: After the 40th bit, `fqud` is high for PHASE_CYC cycles while `sdata` and `wclk` are low, and then it returns low.
- R7: `busy` is high from the cycle after `start` is accepted until the frequency-update pulse ends.
- R8: `done` is high for exactly one cycle, namely the cycle right after the frequency-update pulse ends, and `busy` is low in that cycle.
- R9: A `start` that arrives while `busy` is high is ignored. The word that is sent comes from the inputs as they were when `start` was accepted, even if those inputs change later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; accepted only when idle |
| tune_word | input | FTW_W (32) | Frequency tuning word |
| mult_en | input | 1 | Reference ×6 multiplier enable |
| phase_code | input | PHASE_W (5) | Phase offset in 11.25-degree steps |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sdata | output | 1 | Serial data line |
| wclk | output | 1 | Word clock line |
| fqud | output | 1 | Frequency update (latch) line |

## Verification
The hardest condition to reach from the ports is a new `start` that lands in the middle of a shift while the data inputs also change. A transfer is already running at that moment, so a loader that wrongly accepts the strobe or reads the live inputs goes unnoticed unless the rest of the waveform is compared bit by bit. In one pass of the phase sweep, the bench raises `start` and inverts every data input during the setup phase of bit 10. It then checks every later cycle against the word it originally captured. The bench also applies reset a second time, to show that the serial-enable prefix comes back only after reset.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_EN_WCLK = 3'd1,
      ST_EN_GAP  = 3'd2,
      ST_EN_LOAD = 3'd3,
      ST_SETUP   = 3'd4,
      ST_HIGH    = 3'd5,
      ST_LOW     = 3'd6,
      ST_LATCH   = 3'd7
   } ldr_state_e;

endpackage

// File: rtl/dds_ldr_pacer.sv
module dds_ldr_pacer #(
   parameter int PHASE_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (PHASE_CYC < 1) begin : g_bad_cfg
         $error("dds_ldr_pacer: PHASE_CYC must be at least 1");
      end

      if (PHASE_CYC == 1) begin : g_single
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(PHASE_CYC);
         localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !run || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = run && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/dds_ldr_shreg.sv
module dds_ldr_shreg #(
   parameter int WORD_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              advance,
   output logic              lsb
);

   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_word;
      end else if (advance) begin
         sh_q <= {1'b0, sh_q[WORD_W-1:1]};
      end
   end

   assign lsb = sh_q[0];

endmodule

// File: rtl/dds_ldr_seq.sv
module dds_ldr_seq
   import dds_ldr_pkg::*;
#(
   parameter int WORD_W = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   input  logic bit_in,
   output logic pace_run,
   output logic load,
   output logic advance,
   output logic sdata,
   output logic wclk,
   output logic fqud,
   output logic busy,
   output logic done
);

   localparam int IDX_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(WORD_W - 1);

   ldr_state_e       state_q, state_d;
   logic [IDX_W-1:0] idx_q;
   logic             en_pending_q;
   logic             done_q;

   assign load     = (state_q == ST_IDLE) && start;
   assign advance  = (state_q == ST_LOW) && tick;
   assign pace_run = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start) state_d = en_pending_q ? ST_EN_WCLK : ST_SETUP;
         ST_EN_WCLK: if (tick) state_d = ST_EN_GAP;
         ST_EN_GAP:  if (tick) state_d = ST_EN_LOAD;
         ST_EN_LOAD: if (tick) state_d = ST_SETUP;
         ST_SETUP:   if (tick) state_d = ST_HIGH;
         ST_HIGH:    if (tick) state_d = ST_LOW;
         ST_LOW:     if (tick) state_d = (idx_q == LAST_BIT) ? ST_LATCH : ST_SETUP;
         ST_LATCH:   if (tick) state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         idx_q        <= '0;
         en_pending_q <= 1'b1;
         done_q       <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_LATCH) && tick;
         if (load) begin
            idx_q <= '0;
         end else if (advance) begin
            idx_q <= idx_q + 1'b1;
         end
         if (state_q == ST_EN_LOAD && tick) begin
            en_pending_q <= 1'b0;
         end
      end
   end

   assign sdata = (state_q == ST_SETUP || state_q == ST_HIGH || state_q == ST_LOW) && bit_in;
   assign wclk  = (state_q == ST_HIGH) || (state_q == ST_EN_WCLK);
   assign fqud  = (state_q == ST_LATCH) || (state_q == ST_EN_LOAD);
   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;

   // R6
   fqud_wclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fqud && wclk));

   // R5
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wclk && $past(wclk)) |-> $stable(sdata));

   // R5
   data_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(wclk) && busy && !fqud) |-> $stable(sdata));

   // R7
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(fqud) && $past(busy)));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wclk && !fqud && !sdata));

endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
   parameter int FTW_W     = 32,
   parameter int PHASE_W   = 5,
   parameter int RSV_W     = 2,
   parameter int PHASE_CYC = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FTW_W-1:0]   tune_word,
   input  logic               mult_en,
   input  logic [PHASE_W-1:0] phase_code,
   output logic               busy,
   output logic               done,
   output logic               sdata,
   output logic               wclk,
   output logic               fqud
);

   localparam int CTRL_W = PHASE_W + RSV_W + 1;
   localparam int WORD_W = FTW_W + CTRL_W;

   generate
      if (FTW_W < 1 || PHASE_W < 1 || RSV_W < 0) begin : g_bad_width
         $error("dds_word_loader: illegal field widths");
      end
      if (PHASE_CYC < 1) begin : g_bad_pace
         $error("dds_word_loader: PHASE_CYC must be at least 1");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl_byte;
   logic [WORD_W-1:0] prog_word;

   generate
      if (RSV_W > 0) begin : g_rsv
         assign ctrl_byte = {phase_code, {RSV_W{1'b0}}, mult_en};
      end else begin : g_no_rsv
         assign ctrl_byte = {phase_code, mult_en};
      end
   endgenerate

   assign prog_word = {ctrl_byte, tune_word};

   logic tick, pace_run, load, advance, lsb;

   dds_ldr_pacer #(.PHASE_CYC(PHASE_CYC)) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (pace_run),
      .tick  (tick)
   );

   dds_ldr_shreg #(.WORD_W(WORD_W)) u_shreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (prog_word),
      .advance   (advance),
      .lsb       (lsb)
   );

   dds_ldr_seq #(.WORD_W(WORD_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .tick     (tick),
      .bit_in   (lsb),
      .pace_run (pace_run),
      .load     (load),
      .advance  (advance),
      .sdata    (sdata),
      .wclk     (wclk),
      .fqud     (fqud),
      .busy     (busy),
      .done     (done)
   );

endmodule

// File: tb/dds_word_loader_bench.sv
`timescale 1ns/1ps
module dds_word_loader_bench;

   localparam int P = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] tune_word = '0;
   logic        mult_en = 1'b0;
   logic [4:0]  phase_code = '0;
   logic        busy, done, sdata, wclk, fqud;

   int n_run = 0;
   int n_fail = 0;
   bit poke_now = 1'b0;

   always #2 clk = ~clk;

   dds_word_loader #(.PHASE_CYC(P)) u_dds_word_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .tune_word(tune_word),
      .mult_en(mult_en), .phase_code(phase_code), .busy(busy), .done(done),
      .sdata(sdata), .wclk(wclk), .fqud(fqud)
   );

   // vector = {busy, done, sdata, wclk, fqud}
   task automatic step(input logic [4:0] exp, input string tag);
      @(negedge clk);
      start = 1'b0;
      n_run++;
      if ({busy, done, sdata, wclk, fqud} !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, {busy, done, sdata, wclk, fqud}, exp);
      end
      if (poke_now) begin
         poke_now   = 1'b0;
         start      = 1'b1;
         tune_word  = ~tune_word;
         mult_en    = ~mult_en;
         phase_code = ~phase_code;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      step(5'b00000, "R1 in reset");
      rst_n = 1'b1;
      step(5'b00000, "R1 after reset");
   endtask

   task automatic run_word(input logic [31:0] ftw, input logic m, input logic [4:0] ph,
                           input bit prefix, input bit poke);
      logic [39:0] w;
      string tg;
      // R4 control byte layout: bit0 mult, bits 2:1 zero, bits 7:3 phase
      w = {ph, 2'b00, m, ftw};
      @(negedge clk);
      tune_word = ftw; mult_en = m; phase_code = ph; start = 1'b1;
      if (prefix) begin
         for (int c = 0; c < P; c++) step(5'b10010, "R2 enable wclk");
         for (int c = 0; c < P; c++) step(5'b10000, "R2 enable gap");
         for (int c = 0; c < P; c++) step(5'b10001, "R2 enable fqud");
      end
      for (int i = 0; i < 40; i++) begin
         tg = poke && i > 10 ? "R9 after ignored start" :
              (i < 32 ? "R3/R5/R7 tuning bit" : "R4/R5/R7 control bit");
         for (int c = 0; c < P; c++) begin
            if (poke && i == 10 && c == 0) poke_now = 1'b1;
            step({1'b1, 1'b0, w[i], 2'b00}, tg);
         end
         for (int c = 0; c < P; c++) step({1'b1, 1'b0, w[i], 2'b10}, tg);
         for (int c = 0; c < P; c++) step({1'b1, 1'b0, w[i], 2'b00}, tg);
      end
      for (int c = 0; c < P; c++) step(5'b10001, "R6 latch");
      step(5'b01000, "R8 done pulse");
      step(5'b00000, "R8 done falls");
   endtask

   initial begin
      do_reset();
      run_word(32'h1234_5678, 1'b1, 5'd0, 1'b1, 1'b0);
      for (int ph = 0; ph < 32; ph++) begin
         run_word(32'h9E37_79B9 * ph + ph, ph[0], ph[4:0], 1'b0, ph == 7);
      end
      run_word(32'h0000_0000, 1'b0, 5'd31, 1'b0, 1'b0);
      run_word(32'hFFFF_FFFF, 1'b1, 5'd0, 1'b0, 1'b0);
      do_reset();
      run_word(32'h8000_0001, 1'b0, 5'd16, 1'b1, 1'b0);
      run_word(32'h0F0F_F0F0, 1'b1, 5'd21, 1'b0, 1'b0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule